// File: doc/BRIEF.md
# Nibble-Mode Multiplexed-Address DRAM Model

This block is a synthesizable behavioural model of a one-bit-wide dynamic memory with a multiplexed address bus. It is meant to sit in a testbench or an emulation build as the target of a memory controller under test. The strobes (active-low row strobe, column strobe and write enable) are sampled on a fast system clock. Their falling and rising edges are found by comparing each strobe with its value one clock earlier.

A row address is taken from the bus when the row strobe falls. A column address is taken when the column strobe first falls inside that row cycle. The write enable level at that first column fall picks the kind of access. High means a read or a read-write access, with the output driving. Low means an early write, with the output left floating. If write enable falls while the column strobe is already low, data-in is written at that moment, and the output keeps showing the cell. Further column strobe pulses, while the row strobe stays low, step a two-bit nibble index through up to four bits. The output mode chosen at the first fall holds for the whole burst.

The array is much smaller than the full 20-bit address space, so that simulation stays cheap. The nibble index always takes part in the cell address. The lowest remaining address bits fill up the rest of the array depth.

Top module: `nd_dram_top`

## Requirements
- R1: After reset, dout_oe is 0 and dout is 0, and every array cell reads 0.
- R2: The row address is taken from addr when ras_n falls, and the column address when cas_n first falls while ras_n is low. Later changes on addr within that row cycle have no effect on which cell is accessed.
- R3: While ras_n is high, cas_n pulses are ignored: dout_oe stays 0 and no cell is written.
- R4: A read happens when we_n is high at the first cas_n fall. One clock after that fall, dout_oe is 1 and dout equals the selected cell. One clock after cas_n rises, dout_oe is 0.
- R5: An early write happens when we_n is low at the first cas_n fall. dout_oe stays 0 for every bit of that row cycle, and din is written to the selected cell on the clock that sees the cas_n fall.
- R6: A delayed write happens when we_n falls while cas_n is low inside an access. din is written on the clock that sees the we_n fall. dout_oe stays 1, and dout shows the newly written value. din changes after that strobe do not alter the cell.
- R7: The first nibble index is {row[9], col[9]}. Each further cas_n fall while ras_n stays low adds 1 modulo 4, so the fifth bit is the same cell as the first. The array bit address is {index, L[ARRAY_AW-3:0]}, where L = {row[8:0], col[8:0]}.
- R8: The output mode (driving or floating) is fixed at the first cas_n fall of a row cycle. we_n at later cas_n falls does not change dout_oe.
- R9: Within a burst, a bit is written whenever cas_n falls with we_n low, or we_n falls with cas_n low. The value is returned by any later read of that bit.
- R10: With we_n high throughout an access, din is ignored and the cell keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Active-low synchronous reset; clears the array |
| ras_n | input | 1 | Active-low row address strobe |
| cas_n | input | 1 | Active-low column address strobe |
| we_n | input | 1 | Active-low write enable |
| addr | input | 10 | Multiplexed row/column address |
| din | input | 1 | Write data bit |
| dout | output | 1 | Read data bit, 0 when not driving |
| dout_oe | output | 1 | High when the data output drives |

## Verification
The bench builds the model with its default parameters: a 10-bit address bus and ARRAY_AW of 8, which gives a 256-bit array. With these values the cell address is the nibble index above the low six column bits. Bursts that start at row and column addresses differing only in high bits therefore alias onto the same cells. This makes data left by one burst visible to a later burst that starts at a different nibble index. The same settings also bring the index wrap from 3 to 0 within reach of short 3-, 4- and 5-bit bursts.

// File: rtl/nd_pkg.sv
package nd_pkg;
   typedef enum logic {
      DRV_OFF = 1'b0,
      DRV_ON  = 1'b1
   } drive_mode_e;

   localparam int NIB_W = 2;
endpackage

// File: rtl/nd_edge_det.sv
module nd_edge_det #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] sig_n,
   output logic [N-1:0] fall,
   output logic [N-1:0] rise
);
   if (N < 1) begin : g_bad_n
      $error("nd_edge_det: N must be at least 1");
   end

   for (genvar i = 0; i < N; i++) begin : g_bit
      logic prev_q;
      always_ff @(posedge clk) begin
         if (!rst_n) prev_q <= 1'b1;
         else        prev_q <= sig_n[i];
      end
      assign fall[i] = prev_q & ~sig_n[i];
      assign rise[i] = ~prev_q & sig_n[i];
   end
endmodule

// File: rtl/nd_cell_array.sv
module nd_cell_array #(
   parameter int ARRAY_AW = 8,
   localparam int DEPTH = 1 << ARRAY_AW
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [ARRAY_AW-1:0] wr_idx,
   input  logic                wr_bit,
   input  logic [ARRAY_AW-1:0] rd_idx,
   output logic                rd_bit
);
   if (ARRAY_AW < 3 || ARRAY_AW > 12) begin : g_bad_aw
      $error("nd_cell_array: ARRAY_AW out of range 3..12");
   end

   logic [DEPTH-1:0] cells_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cells_q <= '0;
      end else if (wr_en) begin
         cells_q[wr_idx] <= wr_bit;
      end
   end

   assign rd_bit = cells_q[rd_idx];

   // R9
   write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> cells_q[$past(wr_idx)] == $past(wr_bit));
endmodule

// File: rtl/nd_access_ctrl.sv
module nd_access_ctrl
   import nd_pkg::*;
#(
   parameter int ADDR_W   = 10,
   parameter int ARRAY_AW = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ras_n,
   input  logic                cas_n,
   input  logic                we_n,
   input  logic                ras_fall,
   input  logic                cas_fall,
   input  logic                we_fall,
   input  logic [ADDR_W-1:0]   addr,
   output logic                wr_en,
   output logic [ARRAY_AW-1:0] wr_idx,
   output logic [ARRAY_AW-1:0] rd_idx,
   output logic                drive_en
);
   localparam int LOW_W = 2 * (ADDR_W - 1);
   localparam int SEL_W = ARRAY_AW - NIB_W;

   if (ADDR_W < 2) begin : g_bad_addr
      $error("nd_access_ctrl: ADDR_W must be at least 2");
   end
   if (SEL_W < 1 || SEL_W > LOW_W) begin : g_bad_sel
      $error("nd_access_ctrl: ARRAY_AW does not fit the address");
   end

   function automatic logic [ARRAY_AW-1:0] make_idx(
      input logic [ADDR_W-1:0] r,
      input logic [ADDR_W-1:0] c,
      input logic [NIB_W-1:0]  n
   );
      logic [LOW_W-1:0] low;
      low = {r[ADDR_W-2:0], c[ADDR_W-2:0]};
      return {n, low[SEL_W-1:0]};
   endfunction

   logic [ADDR_W-1:0] row_q, col_q, col_nx;
   logic [NIB_W-1:0]  nib_q, nib_nx;
   logic              burst_q, cas_act_q;
   drive_mode_e       mode_q;
   logic              cas_go, we_go;

   // column fall counts only inside an open row cycle
   assign cas_go = cas_fall & ~ras_n & ~ras_fall;
   assign we_go  = we_fall & cas_act_q & ~cas_n & ~ras_n;

   assign nib_nx = burst_q ? NIB_W'(nib_q + 1'b1) : {row_q[ADDR_W-1], addr[ADDR_W-1]};
   assign col_nx = burst_q ? col_q : addr;

   assign rd_idx   = make_idx(row_q, col_q, nib_q);
   assign wr_idx   = cas_go ? make_idx(row_q, col_nx, nib_nx) : rd_idx;
   assign wr_en    = (cas_go & ~we_n) | we_go;
   assign drive_en = cas_act_q & (mode_q == DRV_ON);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         row_q     <= '0;
         col_q     <= '0;
         nib_q     <= '0;
         burst_q   <= 1'b0;
         cas_act_q <= 1'b0;
         mode_q    <= DRV_OFF;
      end else if (ras_n) begin
         burst_q   <= 1'b0;
         cas_act_q <= 1'b0;
      end else begin
         if (ras_fall) row_q <= addr;
         if (cas_go) begin
            col_q     <= col_nx;
            nib_q     <= nib_nx;
            burst_q   <= 1'b1;
            cas_act_q <= 1'b1;
            if (!burst_q) mode_q <= we_n ? DRV_ON : DRV_OFF;
         end else if (cas_n) begin
            cas_act_q <= 1'b0;
         end
      end
   end

   // R3
   ras_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ras_n |=> !cas_act_q);

   // R7
   nib_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cas_go && burst_q) |=> nib_q == NIB_W'($past(nib_q) + 1'b1));

   // R8
   mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (burst_q && !ras_n) |=> $stable(mode_q));

   // R2
   col_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (burst_q && !ras_n) |=> $stable(col_q));
endmodule

// File: rtl/nd_dram_top.sv
module nd_dram_top #(
   parameter int ADDR_W   = 10,
   parameter int ARRAY_AW = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ras_n,
   input  logic              cas_n,
   input  logic              we_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              din,
   output logic              dout,
   output logic              dout_oe
);
   localparam int STROBES = 3;

   logic [STROBES-1:0] strobes_n, falls, rises;
   logic               wr_en, rd_bit, drive_en;
   logic [ARRAY_AW-1:0] wr_idx, rd_idx;

   assign strobes_n = {we_n, cas_n, ras_n};

   nd_edge_det #(.N(STROBES)) edges_i (
      .clk   (clk),
      .rst_n (rst_n),
      .sig_n (strobes_n),
      .fall  (falls),
      .rise  (rises)
   );

   nd_access_ctrl #(.ADDR_W(ADDR_W), .ARRAY_AW(ARRAY_AW)) ctrl_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .ras_n    (ras_n),
      .cas_n    (cas_n),
      .we_n     (we_n),
      .ras_fall (falls[0]),
      .cas_fall (falls[1]),
      .we_fall  (falls[2]),
      .addr     (addr),
      .wr_en    (wr_en),
      .wr_idx   (wr_idx),
      .rd_idx   (rd_idx),
      .drive_en (drive_en)
   );

   nd_cell_array #(.ARRAY_AW(ARRAY_AW)) cells_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .wr_idx (wr_idx),
      .wr_bit (din),
      .rd_idx (rd_idx),
      .rd_bit (rd_bit)
   );

   assign dout_oe = drive_en;
   assign dout    = drive_en & rd_bit;

   // R4
   oe_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cas_n |=> !dout_oe);

   // R1
   quiet_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dout_oe |-> !dout);

   logic unused_rises;
   assign unused_rises = ^rises;
endmodule

// File: tb/nd_dram_top_tb_top.sv
module nd_dram_top_tb_top;
   localparam int AW = 8;
   localparam int DEPTH = 1 << AW;

   typedef struct packed {
      logic [1:0] kind;   // 0 read, 1 early write, 2 delayed write
      logic [9:0] row;
      logic [9:0] col;
      logic [3:0] data;
      logic [2:0] nbits;
   } vec_t;

   localparam vec_t VECS [10] = '{
      '{2'd1, 10'h200, 10'h205, 4'b1011, 3'd4},
      '{2'd0, 10'h200, 10'h205, 4'b0000, 3'd4},
      '{2'd1, 10'h000, 10'h3FF, 4'b0001, 3'd1},
      '{2'd0, 10'h000, 10'h3FF, 4'b0000, 3'd1},
      '{2'd2, 10'h3FF, 10'h3FF, 4'b0101, 3'd3},
      '{2'd0, 10'h3FF, 10'h3FF, 4'b0000, 3'd4},
      '{2'd0, 10'h000, 10'h005, 4'b0000, 3'd4},
      '{2'd1, 10'h001, 10'h02A, 4'b0110, 3'd2},
      '{2'd0, 10'h001, 10'h02A, 4'b0000, 3'd2},
      '{2'd0, 10'h201, 10'h02A, 4'b0000, 3'd3}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, din = 1'b0;
   logic [9:0] addr = '0;
   logic dout, dout_oe;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;
   logic ref_mem [DEPTH];

   always #4 clk = ~clk;

   nd_dram_top #(.ADDR_W(10), .ARRAY_AW(AW)) dut_i (
      .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
      .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe)
   );

   function automatic int bidx(logic [9:0] r, logic [9:0] c, logic [1:0] n);
      logic [17:0] low;
      low = {r[8:0], c[8:0]};
      return int'({n, low[AW-3:0]});
   endfunction

   task automatic cyc();
      @(negedge clk);
   endtask

   task automatic check(logic got, logic exp, string tag);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %0b expected %0b", tag, got, exp);
      end
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   task automatic open_row(logic [9:0] r, logic [9:0] c);
      addr = r; ras_n = 1'b0; cyc();
      addr = c; cyc();
   endtask

   task automatic close_row();
      cas_n = 1'b1; we_n = 1'b1; ras_n = 1'b1; addr = '0; cyc(); cyc();
   endtask

   task automatic run_access(vec_t v);
      logic [1:0] n;
      int ix;
      open_row(v.row, v.col);
      n = {v.row[9], v.col[9]};
      for (int i = 0; i < int'(v.nbits); i++) begin
         if (i > 0) n = n + 2'd1;
         ix = bidx(v.row, v.col, n);
         if (v.kind == 2'd1) begin
            we_n = 1'b0; din = v.data[i]; cas_n = 1'b0; cyc();
            addr = ~v.col;
            check(dout_oe, 1'b0, "R5 early write floats");
            ref_mem[ix] = v.data[i];
            cas_n = 1'b1; we_n = 1'b1; cyc();
            check(dout_oe, 1'b0, "R5 floats after cas high");
         end else if (v.kind == 2'd0) begin
            we_n = 1'b1; din = ~ref_mem[ix]; cas_n = 1'b0; cyc();
            addr = ~v.col;
            check(dout_oe, 1'b1, "R4 read drives");
            check(dout, ref_mem[ix], "R7 R2 read data at nibble index");
            cas_n = 1'b1; cyc();
            check(dout_oe, 1'b0, "R4 release after cas high");
         end else begin
            we_n = 1'b1; cas_n = 1'b0; cyc();
            check(dout_oe, 1'b1, "R6 delayed write drives");
            check(dout, ref_mem[ix], "R6 old data before strobe");
            din = v.data[i]; we_n = 1'b0; cyc();
            ref_mem[ix] = v.data[i];
            check(dout, v.data[i], "R6 new data after we fall");
            din = ~v.data[i]; we_n = 1'b1; cyc();
            check(dout, v.data[i], "R6 din ignored after strobe");
            cas_n = 1'b1; cyc();
         end
      end
      close_row();
   endtask

   task automatic read_one(logic [9:0] r, logic [9:0] c, logic exp, string tag);
      open_row(r, c);
      we_n = 1'b1; din = ~exp; cas_n = 1'b0; cyc();
      check(dout, exp, tag);
      close_row();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: got timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < DEPTH; i++) ref_mem[i] = 1'b0;
      repeat (4) cyc();
      check(dout_oe, 1'b0, "R1 oe in reset");
      rst_n = 1'b1; cyc();
      check(dout_oe, 1'b0, "R1 oe after reset");
      check(dout, 1'b0, "R1 dout after reset");
      read_one(10'h155, 10'h3C7, 1'b0, "R1 cell zero after reset");
      read_one(10'h000, 10'h000, 1'b0, "R1 cell zero after reset");

      // R3: column strobe with row strobe high, write enable low
      addr = 10'h013; din = 1'b1; we_n = 1'b0; cas_n = 1'b0; cyc();
      check(dout_oe, 1'b0, "R3 no drive with ras high");
      cyc();
      cas_n = 1'b1; we_n = 1'b1; cyc();
      read_one(10'h013, 10'h013, 1'b0, "R3 no write with ras high");

      for (int k = 0; k < 10; k++) run_access(VECS[k]);

      // R7: five-bit read burst, fifth bit equals first
      begin
         logic first_b, fifth_b;
         ref_mem[bidx(10'h000, 10'h211, 2'd1)] = 1'b1;
         run_access('{2'd1, 10'h000, 10'h211, 4'b0001, 3'd1});
         open_row(10'h000, 10'h211);
         first_b = 1'b0; fifth_b = 1'b0;
         for (int i = 0; i < 5; i++) begin
            we_n = 1'b1; cas_n = 1'b0; cyc();
            if (i == 0) first_b = dout;
            if (i == 4) fifth_b = dout;
            cas_n = 1'b1; cyc();
         end
         close_row();
         check(first_b, 1'b1, "R7 first bit of burst");
         check(fifth_b, first_b, "R7 index wraps after four");
      end

      // R8 R9: read-mode burst, second bit written at cas fall with we low
      open_row(10'h000, 10'h030);
      we_n = 1'b1; cas_n = 1'b0; cyc();
      check(dout_oe, 1'b1, "R8 read burst drives");
      cas_n = 1'b1; cyc();
      we_n = 1'b0; din = 1'b1; cas_n = 1'b0; cyc();
      ref_mem[bidx(10'h000, 10'h030, 2'd1)] = 1'b1;
      check(dout_oe, 1'b1, "R8 still drives with we low later");
      check(dout, 1'b1, "R9 written bit visible in burst");
      close_row();
      read_one(10'h000, 10'h230, 1'b1, "R9 burst write persists");

      // R8 R10: early-mode burst, second bit with we high stays floating, no write
      open_row(10'h000, 10'h031);
      we_n = 1'b0; din = 1'b1; cas_n = 1'b0; cyc();
      ref_mem[bidx(10'h000, 10'h031, 2'd0)] = 1'b1;
      cas_n = 1'b1; we_n = 1'b1; cyc();
      din = 1'b1; cas_n = 1'b0; cyc();
      check(dout_oe, 1'b0, "R8 early burst stays floating");
      close_row();
      read_one(10'h000, 10'h231, 1'b0, "R10 we high leaves cell");
      read_one(10'h000, 10'h031, 1'b1, "R5 early write stored");

      // R10: a read with din opposite leaves the cell unchanged
      read_one(10'h000, 10'h005, ref_mem[bidx(10'h000, 10'h005, 2'd0)], "R10 read ignores din");
      read_one(10'h000, 10'h005, ref_mem[bidx(10'h000, 10'h005, 2'd0)], "R10 cell unchanged");

      done = 1'b1;
      summary();
      $finish;
   end
endmodule